// File: doc/BRIEF.md
# Sequential Four-Operand Average with Rounding

This block computes the rounded mean-by-eight of four small unsigned numbers: it adds the four operands, divides the total by eight and rounds to the nearest integer. An exact half rounds up. It trades speed for area. A single adder is shared across several clock cycles, and a small controller sequences it. The adder first builds the running total one operand per cycle. It is then reused to add the rounding increment to the quotient.

The caller waits for `ready`, places all four operands on `ops_i` and pulses `start` for one cycle. The operands are captured at that clock edge, so the caller may change them on the very next cycle. The result appears on `result_o` when `ready` returns. It then stays unchanged until the next accepted command.

Top module: `avg_round_seq`

## Requirements
- R1: While the asynchronous reset `arst_n` is low, and after it is released, `ready` is 1 and `result_o` is 0 until a command is accepted.
- R2: The result equals the sum of the four operands with its three low bits dropped, plus one when those three dropped bits form a value greater than 3. Operand k occupies bits [7k+6:7k] of `ops_i`.
- R3: At the rounding boundary, a remainder of exactly 4 rounds up and a remainder of exactly 3 rounds down.
- R4: A `start` sampled high while `ready` is high is accepted. `ready` falls after that edge and rises again on the sixth following clock edge, and the new result becomes visible on that same edge.
- R5: A `start` pulse while `ready` is low is ignored. It changes neither the result in progress nor the timing of `ready`.
- R6: `result_o` holds its value from the edge that completes a command until the edge that completes the next accepted one.
- R7: The operands are captured on the accepting edge. Changes to `ops_i` after that edge do not affect the result.
- R8: Four operands of 127 give 64, and four operands of 0 give 0.
- R9: The running sum is cleared before each command, so a previous result never leaks into the next one, including for commands issued back to back.
- R10: The accumulation loop stops after exactly four additions and never runs an extra iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, honoured only while ready is high |
| ops_i | input | 28 | Four 7-bit unsigned operands, operand k at bits [7k+6:7k] |
| ready | output | 1 | High while the unit is idle and can accept a command |
| result_o | output | 7 | Registered rounded average |

## Verification
On every cycle, the embedded assertions check the controller invariants. A busy unit never re-enters its load step. The loop counter is non-zero during accumulation, and the loop leaves for rounding right after the last count. The sum is zero after the load step, the result only moves in the rounding step and stays within 64, and ready falls only after a start. The arithmetic itself can only be shown by the bench's scenarios, which compare against a behavioural model on every cycle. These scenarios cover exact rounding at remainders 3 and 4, the extreme operands, operands changed after capture, start pulses while busy, and back-to-back commands.

// File: rtl/avg_pkg.sv
package avg_pkg;

   // controller steps of the shared-adder sequence
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_ACC  = 2'd2,
      ST_RND  = 2'd3
   } avg_state_e;

endpackage

// File: rtl/avg_opbank.sv
// Operand capture bank: one register lane per operand, read through a mux.
module avg_opbank #(
   parameter int OP_W  = 7,
   parameter int N_OPS = 4,
   parameter int IDX_W = 2
) (
   input  logic                    clk,
   input  logic                    arst_n,
   input  logic                    capture_i,
   input  logic [N_OPS*OP_W-1:0]   ops_i,
   input  logic [IDX_W-1:0]        idx_i,
   output logic [OP_W-1:0]         op_o
);

   logic [OP_W-1:0] lane_q [N_OPS];

   for (genvar k = 0; k < N_OPS; k++) begin : g_lane
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            lane_q[k] <= '0;
         end else if (capture_i) begin
            lane_q[k] <= ops_i[k*OP_W +: OP_W];
         end
      end
   end

   always_comb begin
      op_o = '0;
      for (int k = 0; k < N_OPS; k++) begin
         if (idx_i == IDX_W'(k)) op_o = lane_q[k];
      end
   end

endmodule

// File: rtl/avg_shared_adder.sv
// The one adder of the block: accumulation or rounding increment.
module avg_shared_adder #(
   parameter int OP_W  = 7,
   parameter int SUM_W = 9,
   parameter int SHIFT = 3
) (
   input  logic              rnd_mode_i,
   input  logic [SUM_W-1:0]  sum_i,
   input  logic [OP_W-1:0]   op_i,
   output logic [SUM_W-1:0]  out_o
);

   logic [SUM_W-1:0] quot;
   logic             bump;
   logic [SUM_W-1:0] src_a;
   logic [SUM_W-1:0] src_b;

   // quotient = sum with the low SHIFT bits dropped
   assign quot = sum_i >> SHIFT;
   // remainder at least half of the divisor: its top bit is set
   assign bump = sum_i[SHIFT-1];

   always_comb begin
      if (rnd_mode_i) begin
         src_a = quot;
         src_b = {{(SUM_W-1){1'b0}}, bump};
      end else begin
         src_a = sum_i;
         src_b = {{(SUM_W-OP_W){1'b0}}, op_i};
      end
   end

   assign out_o = src_a + src_b;

endmodule

// File: rtl/avg_ctrl.sv
// Start/ready controller with a down-counting operand loop.
module avg_ctrl
   import avg_pkg::*;
#(
   parameter int N_OPS = 4,
   parameter int CNT_W = 3,
   parameter int IDX_W = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               start_i,
   output avg_state_e         state_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               ready_o
);

   avg_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [IDX_W-1:0] idx_q, idx_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      idx_d   = idx_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_LOAD;
         ST_LOAD: begin
            cnt_d   = CNT_W'(N_OPS);
            idx_d   = '0;
            state_d = ST_ACC;
         end
         ST_ACC: begin
            cnt_d = cnt_q - 1'b1;
            idx_d = idx_q + 1'b1;
            // decide on the next count, not the current one
            if (cnt_d == '0) state_d = ST_RND;
         end
         ST_RND:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         idx_q   <= idx_d;
      end
   end

   assign state_o = state_q;
   assign idx_o   = idx_q;
   assign ready_o = (state_q == ST_IDLE);

   // R5
   busy_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q != ST_IDLE) |=> (state_q != ST_LOAD))
      else $error("load entered while busy");

   // R10
   cnt_live_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == ST_ACC) |-> (cnt_q != '0))
      else $error("accumulating with zero count");

   // R10
   last_iter_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == ST_ACC && cnt_q == CNT_W'(1)) |=> (state_q == ST_RND))
      else $error("loop did not stop after last operand");

   // R4
   ready_fall_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(ready_o) |-> $past(start_i))
      else $error("ready dropped without start");

endmodule

// File: rtl/avg_round_seq.sv
// Top: sum and result registers around the shared adder.
module avg_round_seq
   import avg_pkg::*;
#(
   parameter int OP_W  = 7,
   parameter int N_OPS = 4,
   parameter int SHIFT = 3
) (
   input  logic                    clk,
   input  logic                    arst_n,
   input  logic                    start,
   input  logic [N_OPS*OP_W-1:0]   ops_i,
   output logic                    ready,
   output logic [OP_W-1:0]         result_o
);

   localparam int SUM_W   = OP_W + $clog2(N_OPS);
   localparam int RES_W   = SUM_W - SHIFT + 1;
   localparam int CNT_W   = $clog2(N_OPS + 1);
   localparam int IDX_W   = $clog2(N_OPS);
   localparam int RES_MAX = 2 ** (SUM_W - SHIFT);

   if (N_OPS < 2) begin : g_bad_nops
      $error("N_OPS must be at least 2");
   end
   if (SHIFT < 1 || SHIFT >= SUM_W) begin : g_bad_shift
      $error("SHIFT must lie in 1..SUM_W-1");
   end
   if (RES_W > OP_W) begin : g_bad_res
      $error("rounded result does not fit the output width");
   end

   avg_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [OP_W-1:0]   cur_op;
   logic [SUM_W-1:0]  sum_q;
   logic [SUM_W-1:0]  add_out;
   logic [OP_W-1:0]   res_q;
   logic              take;

   assign take = ready & start;

   avg_ctrl #(.N_OPS(N_OPS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk     (clk),
      .arst_n  (arst_n),
      .start_i (start),
      .state_o (state),
      .idx_o   (idx),
      .ready_o (ready)
   );

   avg_opbank #(.OP_W(OP_W), .N_OPS(N_OPS), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .arst_n    (arst_n),
      .capture_i (take),
      .ops_i     (ops_i),
      .idx_i     (idx),
      .op_o      (cur_op)
   );

   avg_shared_adder #(.OP_W(OP_W), .SUM_W(SUM_W), .SHIFT(SHIFT)) u_add (
      .rnd_mode_i (state == ST_RND),
      .sum_i      (sum_q),
      .op_i       (cur_op),
      .out_o      (add_out)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sum_q <= '0;
         res_q <= '0;
      end else begin
         unique case (state)
            ST_LOAD: sum_q <= '0;
            ST_ACC:  sum_q <= add_out;
            ST_RND:  res_q <= OP_W'(add_out[RES_W-1:0]);
            default: ;
         endcase
      end
   end

   assign result_o = res_q;

   // R9
   sum_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state == ST_LOAD) |=> (sum_q == '0))
      else $error("sum not cleared by load");

   // R6
   res_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state != ST_RND) |=> $stable(result_o))
      else $error("result moved outside rounding");

   // R2
   res_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (state == ST_RND) |=> (int'(result_o) <= RES_MAX))
      else $error("rounded result out of range");

endmodule

// File: tb/tb_avg_round_seq.sv
module tb_avg_round_seq;

   localparam int OP_W  = 7;
   localparam int N_OPS = 4;

   logic                  clk = 1'b0;
   logic                  arst_n = 1'b0;
   logic                  start = 1'b0;
   logic [N_OPS*OP_W-1:0] ops = '0;
   logic                  ready;
   logic [OP_W-1:0]       result;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   string cur_req = "R1";

   // behavioural model state
   int m_ready = 1;
   int m_res   = 0;
   int m_left  = 0;
   int m_pend  = 0;

   avg_round_seq dut (
      .clk      (clk),
      .arst_n   (arst_n),
      .start    (start),
      .ops_i    (ops),
      .ready    (ready),
      .result_o (result)
   );

   always #10 clk = ~clk;

   // R2 R3: rounded mean by eight, half rounds up
   function automatic int ref_avg(input logic [N_OPS*OP_W-1:0] v);
      int s = 0;
      for (int i = 0; i < N_OPS; i++) s += int'(v[i*OP_W +: OP_W]);
      return (s + 4) / 8;
   endfunction

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         m_ready = 1; m_res = 0; m_left = 0;
      end else if (m_left > 0) begin
         m_left--;
         if (m_left == 0) begin
            m_ready = 1;
            m_res   = m_pend;
         end
      end else if (m_ready == 1 && start) begin
         m_pend  = ref_avg(ops);   // R7: captured on the accepting edge
         m_left  = 6;              // R4: six edges busy
         m_ready = 0;
      end
   end

   always @(negedge clk) begin
      n_cmp++;
      if (ready !== m_ready[0] || result !== m_res[OP_W-1:0]) begin
         n_bad++;
         $display("FAIL %s: ready=%0b exp %0b, result=%0d exp %0d",
                  cur_req, ready, m_ready[0], result, m_res);
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: cycles=%0d exp below 100000", cyc);
         finish_run();
      end
   end

   function automatic logic [N_OPS*OP_W-1:0] pack4(input int a, b, c, d);
      return {OP_W'(d), OP_W'(c), OP_W'(b), OP_W'(a)};
   endfunction

   // mode 0: plain, 1: change operands after capture, 2: start pulse while busy
   task automatic launch(input int a, b, c, d, input string tag, input int mode);
      while (!ready) @(negedge clk);
      cur_req = tag;
      ops   = pack4(a, b, c, d);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (mode == 1) ops = ~ops;
      if (mode == 2) begin
         @(negedge clk);
         @(negedge clk);
         ops   = pack4(127, 127, 127, 127);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      @(negedge clk);
      while (!ready) @(negedge clk);
   endtask

   initial begin
      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      arst_n = 1'b1;
      repeat (3) @(negedge clk);

      launch(1, 2, 3, 4, "R2", 0);
      launch(10, 10, 10, 9, "R2", 0);
      launch(5, 5, 5, 5, "R3", 0);      // sum 20, remainder 4 -> 3
      launch(3, 0, 0, 0, "R3", 0);      // remainder 3 -> 0
      launch(0, 0, 0, 4, "R3", 0);      // remainder 4 -> 1
      launch(127, 127, 127, 127, "R8", 0);
      launch(0, 0, 0, 0, "R8", 0);
      launch(100, 27, 64, 1, "R7", 1);
      launch(9, 8, 7, 6, "R5", 2);
      launch(50, 60, 70, 80, "R4", 0);

      // R6: idle with wandering operands and no start
      cur_req = "R6";
      for (int i = 0; i < 12; i++) begin
         ops = pack4(i * 11, i * 7, 127 - i, i);
         @(negedge clk);
      end

      // R9 R10: back-to-back commands, large after small and vice versa
      launch(127, 127, 127, 126, "R9", 0);
      launch(1, 0, 0, 0, "R9", 0);
      launch(2, 1, 0, 0, "R10", 0);

      // R2: deterministic sweep of patterns
      for (int i = 0; i < 40; i++) begin
         launch((i * 37) % 128, (i * 53 + 5) % 128, (i * 71 + 9) % 128,
                (i * 13 + 100) % 128, "R2", 0);
      end

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule